// File: doc/BRIEF.md
# SDRAM Start-up Sequencer and Refresh Scheduler

This block is the timing core of an SDRAM controller. Once it is enabled, it waits a programmable power-up delay. It then walks the memory through its bring-up steps: a precharge of all banks, one auto-refresh, and a load of the mode register. After each step it waits a programmable settling delay. When bring-up is done it raises `ready` and starts a periodic refresh timer.

Each refresh deadline is counted into a small pending store. A refresh command goes out only when the bus is not busy. Deadlines that fall due while the bus is occupied are held, up to four of them, and are drained one after another as soon as the bus frees up.

Every command is a strobe that stays high until the memory side acknowledges it. The next settling delay starts from that acknowledge. The data path, address multiplexing and read/write timing are outside this block.

Top module: `sdram_sched`

## Requirements
- R1: While `rst` is high, and on the cycle after any edge that samples `enable` low, `cmd_pre`, `cmd_ref`, `cmd_mrs` and `ready` are all low.
- R2: With `init_delay` = D, `cmd_pre` first goes high on the (D+1)-th rising edge after the edge that first samples `enable` high while the block is idle.
- R3: Bring-up issues precharge, then refresh, then mode load, in that order, and at most one of the three strobes is high in any cycle.
- R4: A command strobe stays high for as long as `cmd_ack` is sampled low. It falls on the edge that samples `cmd_ack` high.
- R5: With `rp_delay` = RP, the bring-up refresh strobe rises on the (RP+1)-th edge after the edge that accepts the precharge acknowledge.
- R6: With `rc_delay` = RC, the edge that accepts any refresh acknowledge is followed by RC+1 edges before the next command can begin. During bring-up, `cmd_mrs` rises on exactly that (RC+1)-th edge.
- R7: With `mrd_delay` = MD, `ready` rises on the (MD+1)-th edge after the edge that accepts the mode-load acknowledge. It stays high while `enable` is high, and `cmd_pre` and `cmd_mrs` stay low while it is high.
- R8: With `ref_period` = P ≥ 1, the bus idle and prompt acknowledges, the first periodic `cmd_ref` rises on the (P+1)-th edge after the edge that raises `ready`, and later ones follow every P edges. P = 0 produces no periodic refresh.
- R9: No refresh strobe begins on an edge that samples `bus_busy` high. Deadlines that pass while the bus is busy are issued back to back once it is released.
- R10: At most 4 deadlines are held. After six or more deadlines pass with the bus busy, exactly 4 refreshes are issued on release before the next deadline.
- R11: Dropping `enable` clears the held deadlines and all timers. After re-enabling, the full bring-up repeats, and the first refresh comes only at the R8 position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Starts bring-up when raised; returns the block to idle when low |
| init_delay | input | 14 | Power-up wait in clock cycles |
| ref_period | input | 10 | Refresh interval in clock cycles, 0 = off |
| mrd_delay | input | 2 | Settling wait after mode load |
| rc_delay | input | 3 | Settling wait after every refresh |
| rp_delay | input | 3 | Settling wait after precharge |
| bus_busy | input | 1 | Another memory access owns the bus |
| cmd_ack | input | 1 | Acknowledge of the strobe that is currently high |
| cmd_pre | output | 1 | Precharge-all command strobe |
| cmd_ref | output | 1 | Auto-refresh command strobe |
| cmd_mrs | output | 1 | Mode-register load strobe |
| ready | output | 1 | Bring-up complete |

## Verification
Wrong state in this block shows up at the strobes, and how soon depends on which state is wrong. A step timer that is off by one moves the next strobe by a cycle, so the gap from acknowledge to the next strobe exposes it within a few cycles of that acknowledge. A wrong held-deadline count cannot be read directly. It shows only after the bus is released, as the wrong number of back-to-back refreshes in the first few dozen cycles, or as an early refresh right after a re-enable when the clear was missed. A drifting period counter shifts the first refresh after `ready` and every later one, so it shows up one period after bring-up.

// File: rtl/sdram_sched_pkg.sv
`timescale 1ns/1ps
package sdram_sched_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POWERUP,
    ST_PRE,
    ST_PRE_WAIT,
    ST_INIT_REF,
    ST_INIT_RC,
    ST_MRS,
    ST_MRD_WAIT,
    ST_RUN,
    ST_REF,
    ST_RC_WAIT
  } sched_state_e;

endpackage

// File: rtl/sdram_step_timer.sv
`timescale 1ns/1ps
// Loadable down counter; zero is high once the loaded count has elapsed.
module sdram_step_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
`timescale 1ns/1ps
// Free-running period counter; tick is one cycle wide, once every period cycles.
module sdram_refresh_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         start,
  input  logic         run,
  input  logic [W-1:0] period,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic         live;
  logic         wrap;

  assign live = (period != '0);
  assign wrap = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (start || wrap)
      cnt_q <= period - W'(1);
    else if (run)
      cnt_q <= cnt_q - W'(1);
  end

  assign tick = wrap && live;
endmodule

// File: rtl/sdram_pending_ctr.sv
`timescale 1ns/1ps
// Saturating store of refresh deadlines not yet served.
module sdram_pending_ctr #(
  parameter int MAX = 4,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic nonzero
);
  logic [W-1:0] cnt_q;
  logic         full;

  assign full = (cnt_q == W'(MAX));

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (inc && !dec && !full)
      cnt_q <= cnt_q + W'(1);
    else if (dec && !inc)
      cnt_q <= cnt_q - W'(1);
  end

  assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/sdram_sched.sv
`timescale 1ns/1ps
module sdram_sched
  import sdram_sched_pkg::*;
#(
  parameter int INIT_W   = 14,
  parameter int REF_W    = 10,
  parameter int MRD_W    = 2,
  parameter int RC_W     = 3,
  parameter int RP_W     = 3,
  parameter int PEND_MAX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [INIT_W-1:0] init_delay,
  input  logic [REF_W-1:0]  ref_period,
  input  logic [MRD_W-1:0]  mrd_delay,
  input  logic [RC_W-1:0]   rc_delay,
  input  logic [RP_W-1:0]   rp_delay,
  input  logic              bus_busy,
  input  logic              cmd_ack,
  output logic              cmd_pre,
  output logic              cmd_ref,
  output logic              cmd_mrs,
  output logic              ready
);
  // The step timer is shared by every wait, so it is sized for the widest one.
  localparam int TMR_W  = INIT_W;
  localparam int PEND_W = $clog2(PEND_MAX + 1);

  sched_state_e st_q, st_d;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             tick;
  logic             pend_any;
  logic             issue;
  logic             start_run;
  logic             running;
  logic             clr;

  assign clr       = !enable;
  assign running   = (st_q == ST_RUN) || (st_q == ST_REF) || (st_q == ST_RC_WAIT);
  assign issue     = enable && (st_q == ST_RUN) && pend_any && !bus_busy;
  assign start_run = enable && (st_q == ST_MRD_WAIT) && tmr_zero;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (!enable) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d     = ST_POWERUP;
          tmr_load = 1'b1;
          tmr_val  = init_delay;
        end
        ST_POWERUP:  if (tmr_zero) st_d = ST_PRE;
        ST_PRE: if (cmd_ack) begin
          st_d     = ST_PRE_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(rp_delay);
        end
        ST_PRE_WAIT: if (tmr_zero) st_d = ST_INIT_REF;
        ST_INIT_REF: if (cmd_ack) begin
          st_d     = ST_INIT_RC;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(rc_delay);
        end
        ST_INIT_RC:  if (tmr_zero) st_d = ST_MRS;
        ST_MRS: if (cmd_ack) begin
          st_d     = ST_MRD_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(mrd_delay);
        end
        ST_MRD_WAIT: if (tmr_zero) st_d = ST_RUN;
        ST_RUN:      if (pend_any && !bus_busy) st_d = ST_REF;
        ST_REF: if (cmd_ack) begin
          st_d     = ST_RC_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(rc_delay);
        end
        ST_RC_WAIT:  if (tmr_zero) st_d = ST_RUN;
        default:     st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cmd_pre <= 1'b0;
      cmd_ref <= 1'b0;
      cmd_mrs <= 1'b0;
      ready   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cmd_pre <= (st_d == ST_PRE);
      cmd_ref <= (st_d == ST_INIT_REF) || (st_d == ST_REF);
      cmd_mrs <= (st_d == ST_MRS);
      ready   <= (st_d == ST_RUN) || (st_d == ST_REF) || (st_d == ST_RC_WAIT);
    end
  end

  sdram_step_timer #(.W(TMR_W)) u_step (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sdram_refresh_timer #(.W(REF_W)) u_period (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .start  (start_run),
    .run    (running),
    .period (ref_period),
    .tick   (tick)
  );

  sdram_pending_ctr #(.MAX(PEND_MAX), .W(PEND_W)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .inc     (tick),
    .dec     (issue),
    .nonzero (pend_any)
  );
endmodule

// File: rtl/sdram_sched_chk.sv
`timescale 1ns/1ps
module sdram_sched_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic bus_busy,
  input logic cmd_ack,
  input logic cmd_pre,
  input logic cmd_ref,
  input logic cmd_mrs,
  input logic ready
);
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_pre, cmd_ref, cmd_mrs}));

  assert_hold_pre_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_pre && !cmd_ack && enable) |=> cmd_pre);

  assert_hold_ref_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_ref && !cmd_ack && enable) |=> cmd_ref);

  assert_hold_mrs_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_mrs && !cmd_ack && enable) |=> cmd_mrs);

  assert_drop_on_ack_R4: assert property (@(posedge clk) disable iff (rst)
    ((cmd_pre || cmd_ref || cmd_mrs) && cmd_ack) |=> !(cmd_pre || cmd_ref || cmd_mrs));

  assert_no_init_cmd_when_ready_R7: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!cmd_pre && !cmd_mrs));

  assert_no_ref_start_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (ready && bus_busy && !cmd_ref) |=> !cmd_ref);

  assert_idle_after_disable_R11: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!ready && !cmd_pre && !cmd_ref && !cmd_mrs));
endmodule

bind sdram_sched sdram_sched_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .bus_busy (bus_busy),
  .cmd_ack  (cmd_ack),
  .cmd_pre  (cmd_pre),
  .cmd_ref  (cmd_ref),
  .cmd_mrs  (cmd_mrs),
  .ready    (ready)
);

// File: tb/sdram_sched_test.sv
`timescale 1ns/1ps
module sdram_sched_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [13:0] init_delay = '0;
  logic [9:0]  ref_period = '0;
  logic [1:0]  mrd_delay = '0;
  logic [2:0]  rc_delay = '0;
  logic [2:0]  rp_delay = '0;
  logic        bus_busy = 1'b0;
  logic        cmd_ack = 1'b0;
  logic        ack_en = 1'b1;
  logic        cmd_pre, cmd_ref, cmd_mrs, ready;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_sched uut (
    .clk(clk), .rst(rst), .enable(enable), .init_delay(init_delay),
    .ref_period(ref_period), .mrd_delay(mrd_delay), .rc_delay(rc_delay),
    .rp_delay(rp_delay), .bus_busy(bus_busy), .cmd_ack(cmd_ack),
    .cmd_pre(cmd_pre), .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs), .ready(ready)
  );

  // Memory-side responder: acknowledges any high strobe one edge later.
  initial forever begin
    @(negedge clk);
    cmd_ack <= ack_en && (cmd_pre || cmd_ref || cmd_mrs);
  end

  // {init_delay, rp, rc, mrd}
  localparam logic [21:0] VECS [5] = '{
    {14'd5,   3'd1, 3'd2, 2'd0},
    {14'd0,   3'd0, 3'd0, 2'd0},
    {14'd12,  3'd7, 3'd7, 2'd3},
    {14'd1,   3'd3, 3'd5, 2'd1},
    {14'd300, 3'd2, 3'd4, 2'd2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic wait_high(input int which, output int t);
    t = -1;
    for (int i = 0; i < 20000 && t < 0; i++) begin
      @(negedge clk);
      if ((which == 0 && cmd_pre) || (which == 1 && cmd_ref) ||
          (which == 2 && cmd_mrs) || (which == 3 && ready))
        t = cyc;
    end
  endtask

  // Full bring-up with timing checks; returns the cycle at which ready was seen.
  task automatic run_init(input int d, input int rp, input int rc, input int md,
                          output int t_ready);
    int t0, tp, tf, tm;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!ready && !cmd_pre && !cmd_ref && !cmd_mrs, "R1 idle while disabled",
          {ready, cmd_pre, cmd_ref, cmd_mrs}, 0);
    init_delay = 14'(d); rp_delay = 3'(rp); rc_delay = 3'(rc); mrd_delay = 2'(md);
    enable = 1'b1;
    t0 = cyc;
    wait_high(0, tp);
    check(tp - t0 == d + 2, "R2 power-up delay", tp - t0, d + 2);
    check(!cmd_ref && !cmd_mrs && !ready, "R3 precharge first", {cmd_ref, cmd_mrs}, 0);
    wait_high(1, tf);
    check(tf - tp == rp + 2, "R5 precharge delay", tf - tp, rp + 2);
    wait_high(2, tm);
    check(tm - tf == rc + 2, "R6 row-cycle delay", tm - tf, rc + 2);
    wait_high(3, t_ready);
    check(t_ready - tm == md + 2, "R7 mode-load delay", t_ready - tm, md + 2);
  endtask

  task automatic count_refs(input int ncyc, output int n);
    logic prev;
    prev = cmd_ref;
    n = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (cmd_ref && !prev) n++;
      prev = cmd_ref;
    end
  endtask

  task automatic first_ref(output int t);
    t = -1;
    for (int i = 0; i < 3000 && t < 0; i++) begin
      @(negedge clk);
      if (cmd_ref) t = cyc;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d cycles", cyc, 190000);
    report();
    $finish;
  end

  initial begin
    int tr, t, n, tprev;
    repeat (4) @(negedge clk);
    check(!ready && !cmd_pre && !cmd_ref && !cmd_mrs, "R1 reset state",
          {ready, cmd_pre, cmd_ref, cmd_mrs}, 0);
    rst = 1'b0;
    ref_period = 10'd1000;

    // Table-driven bring-up timing
    foreach (VECS[k]) begin
      run_init(int'(VECS[k][21:8]), int'(VECS[k][7:5]), int'(VECS[k][4:2]),
               int'(VECS[k][1:0]), tr);
      repeat (3) @(negedge clk);
      check(ready && !cmd_pre && !cmd_mrs, "R7 ready holds", ready, 1);
    end

    // R4: strobe held without acknowledge, drops after it
    @(negedge clk);
    enable = 1'b0;
    ack_en = 1'b0;
    @(negedge clk);
    init_delay = 14'd2; rp_delay = 3'd3;
    enable = 1'b1;
    wait_high(0, t);
    n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (cmd_pre) n++;
    end
    check(n == 8, "R4 strobe held until ack", n, 8);
    @(posedge clk);
    ack_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!cmd_pre && !cmd_ref, "R4 strobe drops after ack", cmd_pre, 0);

    // R8: periodic spacing
    ref_period = 10'd50;
    run_init(4, 1, 2, 1, tr);
    first_ref(t);
    check(t - tr == 51, "R8 first refresh position", t - tr, 51);
    tprev = t;
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      first_ref(t);
      check(t - tprev == 50, "R8 refresh interval", t - tprev, 50);
      tprev = t;
    end

    // R8: period zero disables refresh
    ref_period = 10'd0;
    run_init(2, 0, 1, 0, tr);
    count_refs(3000, n);
    check(n == 0, "R8 zero period no refresh", n, 0);

    // R9: two deadlines held while busy, issued on release
    ref_period = 10'd1000;
    run_init(3, 1, 2, 1, tr);
    bus_busy = 1'b1;
    count_refs(2500, n);
    check(n == 0, "R9 no refresh while busy", n, 0);
    bus_busy = 1'b0;
    count_refs(200, n);
    check(n == 2, "R9 held refreshes drained", n, 2);

    // R10: six deadlines while busy, only four held
    run_init(3, 1, 2, 1, tr);
    bus_busy = 1'b1;
    count_refs(6500, n);
    check(n == 0, "R9 no refresh while busy long", n, 0);
    bus_busy = 1'b0;
    count_refs(200, n);
    check(n == 4, "R10 saturation at four", n, 4);

    // R11: disable clears held deadlines and timers
    ref_period = 10'd100;
    run_init(3, 1, 1, 0, tr);
    bus_busy = 1'b1;
    count_refs(250, n);
    enable = 1'b0;
    @(negedge clk);
    check(!ready && !cmd_ref, "R11 disable drops ready", ready, 0);
    bus_busy = 1'b0;
    run_init(3, 1, 1, 0, tr);
    first_ref(t);
    check(t - tr == 101, "R11 no stale refresh after re-enable", t - tr, 101);

    report();
    $finish;
  end
endmodule